// File: doc/BRIEF.md
# Stereo Output Word Serializer

This block sends a pair of filter results, one for the left channel and one for the right, to a controller over two single-bit output lines. The datapath offers a result pair with a one-cycle valid pulse. The pair is held in a one-entry holding register. It goes onto the lines only at a cycle where the frame strobe is high and the serializer is free. From that cycle on, each line carries one bit of its word per clock, sign bit first, and the ready flag stays high for the whole word.

A pair that arrives during a transmission waits in the holding register for the next frame strobe after the current word ends. A second pair that arrives before the first has started replaces it and sets a sticky overflow flag. A synchronous clear from the controller stops the serializer at once. It drops the ready flag, zeroes both shift registers and discards any waiting pair.

Top module: `stereo_word_serializer`

## Requirements
- R1: While reset is asserted and after it is released, out_ready_o, both data lines and overflow_o are 0 until a word starts.
- R2: A word starts only at a rising clock edge where frame_i is 1 and a pair is held. After that edge out_ready_o is 1 and each line carries bit WORD_W-1 (the sign bit) of its word.
- R3: Each line sends the WORD_W bits of its word (40 by default) from the most significant bit to the least significant bit, one bit per clock. Both lanes are in step.
- R4: out_ready_o stays 1 for exactly WORD_W cycles per word. If frame_i is 1 at the edge that ends a word and a pair is held, the next word follows without a gap.
- R5: While out_ready_o is 0, both data lines are 0.
- R6: A pair presented during a transmission is held. Frame strobes during that transmission do not start it. It starts at the first frame strobe after the word ends.
- R7: If res_valid_i is 1 while a pair is held and that pair is not started at the same edge, the new pair replaces the held one. overflow_o then becomes 1 and stays 1 until clear or reset.
- R8: clear_i=1 at an edge ends any word: out_ready_o and both lines are 0 after that edge. The held pair is discarded, so a later frame strobe starts nothing. overflow_o returns to 0.
- R9: A frame strobe with no pair held leaves out_ready_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Data clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous abort and clear from the controller |
| frame_i | input | 1 | Frame strobe, one cycle wide |
| res_valid_i | input | 1 | Result pair valid pulse from the datapath |
| res_left_i | input | WORD_W | Left-channel result |
| res_right_i | input | WORD_W | Right-channel result |
| out_left_o | output | 1 | Left serial data line |
| out_right_o | output | 1 | Right serial data line |
| out_ready_o | output | 1 | High while a word is on the lines |
| overflow_o | output | 1 | Sticky flag: a held pair was overwritten |

## Verification
The bit counter shows at the ports as the length of the ready window. A miscount gives a window shorter or longer than WORD_W cycles, and this shows in the first word. A fault in the holding register or its start condition shows as a word that is missing, sent twice or sent too early, and the scoreboard finds it at the next word. A shift-register fault corrupts the word on the lines within WORD_W cycles. Stale data left in the shift register shows as a high data line while ready is low.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int unsigned NUM_LANES = 2;
  localparam int unsigned LANE_L = 0;
  localparam int unsigned LANE_R = 1;
endpackage

// File: rtl/ser_hold_buf.sv
module ser_hold_buf #(
  parameter int unsigned WORD_W = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              put_i,
  input  logic [WORD_W-1:0] put_l_i,
  input  logic [WORD_W-1:0] put_r_i,
  input  logic              take_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] hold_l_o,
  output logic [WORD_W-1:0] hold_r_o,
  output logic              ovf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      hold_l_o <= '0;
      hold_r_o <= '0;
      ovf_o    <= 1'b0;
    end else if (clear_i) begin
      valid_o  <= 1'b0;
      hold_l_o <= '0;
      hold_r_o <= '0;
      ovf_o    <= 1'b0;
    end else begin
      if (put_i) begin
        valid_o  <= 1'b1;
        hold_l_o <= put_l_i;
        hold_r_o <= put_r_i;
        // overwrite of a pair that is not leaving this cycle
        if (valid_o && !take_i) ovf_o <= 1'b1;
      end else if (take_i) begin
        valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ser_bit_timer.sv
module ser_bit_timer #(
  parameter int unsigned WORD_W = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic start_i,
  output logic busy_o,
  output logic last_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= CNT_TOP;
      busy_o <= 1'b1;
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign last_o = busy_o && (cnt_q == '0);
endmodule

// File: rtl/ser_lane.sv
module ser_lane #(
  parameter int unsigned WORD_W = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] sreg_q;

  // zeros fill from the bottom, so an idle lane reads 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sreg_q <= '0;
    else if (clear_i) sreg_q <= '0;
    else if (load_i)  sreg_q <= word_i;
    else              sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
  end

  assign bit_o = sreg_q[WORD_W-1];
endmodule

// File: rtl/stereo_word_serializer.sv
module stereo_word_serializer
  import ser_pkg::*;
#(
  parameter int unsigned WORD_W = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              frame_i,
  input  logic              res_valid_i,
  input  logic [WORD_W-1:0] res_left_i,
  input  logic [WORD_W-1:0] res_right_i,
  output logic              out_left_o,
  output logic              out_right_o,
  output logic              out_ready_o,
  output logic              overflow_o
);
  logic              hold_valid;
  logic [WORD_W-1:0] hold_l, hold_r;
  logic              busy, last;
  logic              start;
  logic [NUM_LANES-1:0][WORD_W-1:0] lane_word;
  logic [NUM_LANES-1:0]             lane_bit;

  // start on a frame strobe when free or finishing the last bit
  assign start = frame_i && hold_valid && (!busy || last) && !clear_i;

  ser_hold_buf #(.WORD_W(WORD_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .put_i    (res_valid_i),
    .put_l_i  (res_left_i),
    .put_r_i  (res_right_i),
    .take_i   (start),
    .valid_o  (hold_valid),
    .hold_l_o (hold_l),
    .hold_r_o (hold_r),
    .ovf_o    (overflow_o)
  );

  ser_bit_timer #(.WORD_W(WORD_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .start_i (start),
    .busy_o  (busy),
    .last_o  (last)
  );

  assign lane_word[LANE_L] = hold_l;
  assign lane_word[LANE_R] = hold_r;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    ser_lane #(.WORD_W(WORD_W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear_i),
      .load_i  (start),
      .word_i  (lane_word[g]),
      .bit_o   (lane_bit[g])
    );
  end

  assign out_left_o  = lane_bit[LANE_L];
  assign out_right_o = lane_bit[LANE_R];
  assign out_ready_o = busy;
endmodule

// File: rtl/stereo_word_serializer_chk.sv
module stereo_word_serializer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic clear_i,
  input logic frame_i,
  input logic out_left_o,
  input logic out_right_o,
  input logic out_ready_o,
  input logic overflow_o
);
  // R2
  ready_needs_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_ready_o && !$past(out_ready_o)) |-> $past(frame_i));
  // R5
  idle_lines_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_ready_o |-> (!out_left_o && !out_right_o));
  // R8
  clear_drops_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!out_ready_o && !overflow_o));
  // R7
  overflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !clear_i) |=> overflow_o);
endmodule

bind stereo_word_serializer stereo_word_serializer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clear_i     (clear_i),
  .frame_i     (frame_i),
  .out_left_o  (out_left_o),
  .out_right_o (out_right_o),
  .out_ready_o (out_ready_o),
  .overflow_o  (overflow_o)
);

// File: tb/tb_stereo_word_serializer.sv
`timescale 1ns/1ps
module tb_stereo_word_serializer;
  localparam int W = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0, frame = 1'b0, res_valid = 1'b0;
  logic [W-1:0] res_l = '0, res_r = '0;
  logic out_l, out_r, out_rdy, ovf;

  int total = 0, bad = 0;
  logic [2*W-1:0] exp_q[$];
  logic abort = 1'b0;
  int bit_cnt = 0;
  logic [W-1:0] acc_l, acc_r;

  always #4 clk = ~clk;

  stereo_word_serializer #(.WORD_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .frame_i(frame),
    .res_valid_i(res_valid), .res_left_i(res_l), .res_right_i(res_r),
    .out_left_o(out_l), .out_right_o(out_r), .out_ready_o(out_rdy),
    .overflow_o(ovf)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic give(input logic [W-1:0] l, input logic [W-1:0] r, input bit expect_tx);
    if (expect_tx) exp_q.push_back({l, r});
    res_valid = 1'b1; res_l = l; res_r = r;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic frame_pulse();
    frame = 1'b1;
    @(negedge clk);
    frame = 1'b0;
  endtask

  // monitor: rebuild words from the lines and compare with the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (abort) begin
        bit_cnt = 0;
      end else if (out_rdy) begin
        acc_l = {acc_l[W-2:0], out_l};
        acc_r = {acc_r[W-2:0], out_r};
        bit_cnt++;
        if (bit_cnt == W) begin
          bit_cnt = 0;
          if (exp_q.size() == 0) chk(1'b0, "R3 unexpected word", acc_l, '0);
          else begin
            logic [2*W-1:0] e;
            e = exp_q.pop_front();
            chk(acc_l == e[2*W-1:W], "R3 left word", acc_l, e[2*W-1:W]);
            chk(acc_r == e[W-1:0], "R3 right word", acc_r, e[W-1:0]);
          end
        end
      end else begin
        if (bit_cnt != 0) chk(1'b0, "R4 ready window short", W'(bit_cnt), W'(W));
        bit_cnt = 0;
        if (out_l || out_r) chk(1'b0, "R5 idle line high", {out_l, out_r}, '0);
      end
    end
  end

  initial begin
    #400000;
    chk(1'b0, "watchdog", '0, '0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(1);
    chk(!out_rdy && !out_l && !out_r && !ovf, "R1 in reset", {out_rdy, out_l, out_r, ovf}, '0);
    tick(2);
    rst_n = 1'b1;
    tick(3);
    chk(!out_rdy && !ovf, "R1 after reset", {out_rdy, ovf}, '0);

    // R9: frame with nothing held
    frame_pulse();
    chk(!out_rdy, "R9 empty frame", W'(out_rdy), '0);

    // R2: held pair waits for frame
    give(40'h80_1234_5678, 40'h12_3456_789A, 1'b1);
    tick(5);
    chk(!out_rdy, "R2 no start without frame", W'(out_rdy), '0);
    frame_pulse();
    chk(out_rdy && out_l && !out_r, "R2 start with msb", {out_rdy, out_l, out_r}, 3'b110);
    tick(45);
    chk(!out_rdy && exp_q.size() == 0, "R4 word done", W'(exp_q.size()), '0);

    // R6: arrival during transmission
    give(40'hA5_A5A5_A5A5, 40'h5A_5A5A_5A5A, 1'b1);
    frame_pulse();
    tick(10);
    give(40'hFF_0000_FFFF, 40'h00_FFFF_0000, 1'b1);
    frame_pulse();
    tick(30);
    chk(!out_rdy, "R6 held pair waits", W'(out_rdy), '0);
    frame_pulse();
    chk(out_rdy && out_l && !out_r, "R6 held pair starts", {out_rdy, out_l, out_r}, 3'b110);
    tick(45);
    chk(exp_q.size() == 0, "R6 both words sent", W'(exp_q.size()), '0);

    // R7: overwrite
    give(40'h11_1111_1111, 40'h22_2222_2222, 1'b0);
    give(40'hC3_0F0F_F0F0, 40'h3C_F0F0_0F0F, 1'b1);
    chk(ovf, "R7 overflow set", W'(ovf), 1);
    frame_pulse();
    tick(45);
    chk(ovf && exp_q.size() == 0, "R7 sticky and newer word sent", {ovf, W'(exp_q.size())}, 1);

    // R4: back-to-back at the boundary edge
    give(40'h01_0203_0405, 40'hF1_F2F3_F4F5, 1'b1);
    frame_pulse();
    give(40'hDE_ADBE_EF00, 40'h00_0000_0001, 1'b1);
    tick(38);
    frame_pulse();
    chk(out_rdy && out_l, "R4 back-to-back no gap", {out_rdy, out_l}, 2'b11);
    tick(45);
    chk(exp_q.size() == 0, "R4 both words sent", W'(exp_q.size()), '0);

    // R8: clear
    give(40'hFF_FFFF_FFFF, 40'hFF_FFFF_FFFF, 1'b0);
    frame_pulse();
    give(40'h77_7777_7777, 40'h77_7777_7777, 1'b0);
    tick(10);
    abort = 1'b1; clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    chk(!out_rdy && !out_l && !out_r && !ovf, "R8 clear", {out_rdy, out_l, out_r, ovf}, '0);
    frame_pulse();
    chk(!out_rdy, "R8 held pair discarded", W'(out_rdy), '0);
    tick(2);
    abort = 1'b0;
    tick(5);

    chk(exp_q.size() == 0, "R3 scoreboard empty", W'(exp_q.size()), '0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule